// File: doc/BRIEF.md
# UART Interrupt Source Clearing Unit

This block holds the pending interrupt conditions of one serial channel. Each condition has its own rule for clearing. Six sticky flags record the events that arrive from the receive path, the transmit path, the line-status logic, the modem-control logic and the flow-control logic. Each flag stays set until its clearing trigger occurs. The triggers differ by source:

- Two receive flags follow the receive FIFO. One clears when the occupancy falls under the programmed trigger level. The other clears when the FIFO runs empty.
- The other flags clear when the host reads a particular status register. Those reads arrive here as one-cycle strobes from the bus interface.

The flags are combined into a single interrupt request. Each source has its own enable bit. A fixed-priority encoder gives the identifier of the most urgent enabled source, and the interrupt status register reports that identifier. The FIFOs, the baud logic, the shifters and the host bus are separate blocks. They supply this block with level status and single-cycle event strobes.

Top module: `uirq_clear_unit`

## Requirements
- R1: While rst_n is low, and right after it is released, pending is 0, irq is 0 and irq_code is 0.
- R2: pending bit 2 (receive data ready) is 1 in the cycle after rx_fifo_count >= rx_trig_level, and 0 in the cycle after rx_fifo_count < rx_trig_level. Register reads have no effect on it.
- R3: pending bit 1 (receive time-out) sets one cycle after an rx_timeout_evt pulse. It stays set while rx_fifo_empty is 0, whatever the FIFO count or register reads do. It clears one cycle after rx_fifo_empty is 1.
- R4: pending bit 0 (line status) sets on ls_evt and clears only on lsr_rd. isr_rd and msr_rd leave it unchanged.
- R5: pending bit 3 (transmit ready) sets on tx_ready_evt and clears only on isr_rd. msr_rd leaves it unchanged.
- R6: pending bit 4 (modem status) sets on any of modem_evt, rtscts_evt or dtrdsr_evt, and clears only on msr_rd. isr_rd leaves it unchanged.
- R7: pending bit 5 (flow control / special character) sets on xonxoff_evt or spchar_evt, and clears only on isr_rd. msr_rd leaves it unchanged.
- R8: When a source's set event and its clear condition arrive in the same cycle, the flag is 1 in the following cycle.
- R9: irq is the OR of pending[i] AND src_enable[i] over all six bits. It follows src_enable in the same cycle. A disabled source still shows in pending.
- R10: irq_code names the highest-priority pending source that is enabled. The order is line status = 1, receive time-out = 2, receive data ready = 3, transmit ready = 4, modem status = 5, flow control = 6. The code is 0 when none is pending and enabled.
- R11: A flag with neither a set event nor a clear condition in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_fifo_count | input | CNT_W | Receive FIFO occupancy |
| rx_fifo_empty | input | 1 | Receive FIFO empty level |
| rx_trig_level | input | CNT_W | Programmed receive trigger level |
| rx_timeout_evt | input | 1 | Receive time-out event pulse |
| ls_evt | input | 1 | Line-status error event pulse |
| tx_ready_evt | input | 1 | Transmit-ready event pulse |
| modem_evt | input | 1 | Modem input change event pulse |
| rtscts_evt | input | 1 | RTS/CTS delta event pulse |
| dtrdsr_evt | input | 1 | DTR/DSR delta event pulse |
| xonxoff_evt | input | 1 | Xon/Xoff delta event pulse |
| spchar_evt | input | 1 | Special character detected pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| isr_rd | input | 1 | Interrupt status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| src_enable | input | 6 | Per-source enable, same bit order as pending |
| pending | output | 6 | Pending flags (bit order given in R2 to R7) |
| irq | output | 1 | Combined interrupt request |
| irq_code | output | 3 | Source identifier of the winning source |

## Verification
A flag that has taken the wrong value shows on pending one cycle after the stimulus. It shows on irq and irq_code in that same cycle whenever the source is enabled. The ordering of set against clear is a real risk. If the priority goes the wrong way, a ready or delta event lost during a status read leaves pending at 0 in the next cycle. If a register read is decoded to the wrong flag, some other bit of pending drops. If the priority encoder's ranking is wrong, irq_code shows the wrong identifier as soon as two enabled sources are pending together. Sticky flags never fix themselves, so any such error stays visible until the next proper clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC   = 6;
  localparam int CODE_W = 3;

  // Bit positions in the pending vector, lowest index is most urgent.
  localparam int SRC_LSTAT = 0;
  localparam int SRC_RXTO  = 1;
  localparam int SRC_RXRDY = 2;
  localparam int SRC_TXRDY = 3;
  localparam int SRC_MODEM = 4;
  localparam int SRC_FLOW  = 5;

  typedef enum logic [CODE_W-1:0] {
    ICODE_NONE  = 3'd0,
    ICODE_LSTAT = 3'd1,
    ICODE_RXTO  = 3'd2,
    ICODE_RXRDY = 3'd3,
    ICODE_TXRDY = 3'd4,
    ICODE_MODEM = 3'd5,
    ICODE_FLOW  = 3'd6
  } irq_code_e;

endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // Set has priority over clear when both arrive together.
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign q_o = flag_q;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));

  // R4
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/irq_rx_level.sv
module irq_rx_level #(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] trig_i,
  output logic             at_or_above_o
);

  always_comb begin
    at_or_above_o = (count_i >= trig_i);
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0]   req_i,
  output logic [CODE_W-1:0] code_o
);

  // Scan from the least urgent upward so the lowest index is written last.
  always_comb begin
    code_o = ICODE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o = CODE_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/uirq_clear_unit.sv
module uirq_clear_unit
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_fifo_count,
  input  logic             rx_fifo_empty,
  input  logic [CNT_W-1:0] rx_trig_level,
  input  logic             rx_timeout_evt,
  input  logic             ls_evt,
  input  logic             tx_ready_evt,
  input  logic             modem_evt,
  input  logic             rtscts_evt,
  input  logic             dtrdsr_evt,
  input  logic             xonxoff_evt,
  input  logic             spchar_evt,
  input  logic             lsr_rd,
  input  logic             isr_rd,
  input  logic             msr_rd,
  input  logic [5:0]       src_enable,
  output logic [5:0]       pending,
  output logic             irq,
  output logic [2:0]       irq_code
);

  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] clr_v;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] live_v;
  logic            rx_hi;

  irq_rx_level #(.CNT_W(CNT_W)) u_rx_level (
    .count_i       (rx_fifo_count),
    .trig_i        (rx_trig_level),
    .at_or_above_o (rx_hi)
  );

  // Per-source set events and clearing conditions.
  always_comb begin
    set_v[SRC_LSTAT] = ls_evt;
    clr_v[SRC_LSTAT] = lsr_rd;

    set_v[SRC_RXTO]  = rx_timeout_evt;
    clr_v[SRC_RXTO]  = rx_fifo_empty;

    set_v[SRC_RXRDY] = rx_hi;
    clr_v[SRC_RXRDY] = ~rx_hi;

    set_v[SRC_TXRDY] = tx_ready_evt;
    clr_v[SRC_TXRDY] = isr_rd;

    set_v[SRC_MODEM] = modem_evt | rtscts_evt | dtrdsr_evt;
    clr_v[SRC_MODEM] = msr_rd;

    set_v[SRC_FLOW]  = xonxoff_evt | spchar_evt;
    clr_v[SRC_FLOW]  = isr_rd;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    irq_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (pend_q[g])
    );
  end

  always_comb begin
    live_v = pend_q & src_enable;
    irq    = |live_v;
  end

  irq_prio_enc u_prio (
    .req_i  (live_v),
    .code_o (irq_code)
  );

  assign pending = pend_q;

  // R9
  irq_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_code != 3'd0));

  // R10
  lstat_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending[SRC_LSTAT] && src_enable[SRC_LSTAT]) |-> irq_code == 3'd1);

  // R3
  rxto_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_empty && !rx_timeout_evt) |=> !pending[SRC_RXTO]);

  // R2
  rxrdy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_count < rx_trig_level) |=> !pending[SRC_RXRDY]);

endmodule

// File: tb/test_uirq_clear_unit.sv
module test_uirq_clear_unit;

  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] rx_fifo_count;
  logic          rx_fifo_empty;
  logic [CW-1:0] rx_trig_level;
  logic          rx_timeout_evt, ls_evt, tx_ready_evt, modem_evt;
  logic          rtscts_evt, dtrdsr_evt, xonxoff_evt, spchar_evt;
  logic          lsr_rd, isr_rd, msr_rd;
  logic [5:0]    src_enable;
  logic [5:0]    pending;
  logic          irq;
  logic [2:0]    irq_code;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  uirq_clear_unit #(.CNT_W(CW)) i_uirq_clear_unit (
    .clk, .rst_n, .rx_fifo_count, .rx_fifo_empty, .rx_trig_level,
    .rx_timeout_evt, .ls_evt, .tx_ready_evt, .modem_evt, .rtscts_evt,
    .dtrdsr_evt, .xonxoff_evt, .spchar_evt, .lsr_rd, .isr_rd, .msr_rd,
    .src_enable, .pending, .irq, .irq_code
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    rx_timeout_evt = 0; ls_evt = 0; tx_ready_evt = 0; modem_evt = 0;
    rtscts_evt = 0; dtrdsr_evt = 0; xonxoff_evt = 0; spchar_evt = 0;
    lsr_rd = 0; isr_rd = 0; msr_rd = 0;
  endtask

  // One clock: inputs driven at negedge, result sampled at next negedge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic t_reset();
    quiet();
    rst_n = 0; rx_fifo_count = 0; rx_fifo_empty = 1; rx_trig_level = 4;
    src_enable = 6'h3f;
    #35;
    chk("R1 pending in reset", 32'(pending), 0);
    @(negedge clk); rst_n = 1;
    tick();
    chk("R1 pending after reset", 32'(pending), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 code after reset", 32'(irq_code), 0);
  endtask

  task automatic t_rxrdy();
    rx_fifo_empty = 0; rx_fifo_count = 3; tick();
    chk("R2 below trigger", 32'(pending[2]), 0);
    rx_fifo_count = 4; tick();
    chk("R2 at trigger", 32'(pending[2]), 1);
    rx_fifo_count = 5; isr_rd = 1; lsr_rd = 1; msr_rd = 1; tick();
    chk("R2 reads ignored", 32'(pending[2]), 1);
    rx_fifo_count = 3; tick();
    chk("R2 drained below", 32'(pending[2]), 0);
    chk("R11 rxto untouched", 32'(pending[1]), 0);
  endtask

  task automatic t_rxto();
    rx_fifo_count = 2; rx_fifo_empty = 0; rx_timeout_evt = 1; tick();
    chk("R3 timeout set", 32'(pending[1]), 1);
    rx_fifo_count = 1; tick();
    chk("R3 partial read holds", 32'(pending[1]), 1);
    isr_rd = 1; lsr_rd = 1; msr_rd = 1; tick();
    chk("R3 reads ignored", 32'(pending[1]), 1);
    rx_fifo_count = 0; rx_fifo_empty = 1; tick();
    chk("R3 cleared on empty", 32'(pending[1]), 0);
    rx_timeout_evt = 1; tick();
    chk("R8 timeout wins over empty", 32'(pending[1]), 1);
    tick();
    chk("R3 empty clears next", 32'(pending[1]), 0);
  endtask

  task automatic t_lstat();
    ls_evt = 1; tick();
    chk("R4 set", 32'(pending[0]), 1);
    isr_rd = 1; msr_rd = 1; tick();
    chk("R4 other reads ignored", 32'(pending[0]), 1);
    tick();
    chk("R11 hold", 32'(pending[0]), 1);
    lsr_rd = 1; tick();
    chk("R4 lsr read clears", 32'(pending[0]), 0);
    ls_evt = 1; lsr_rd = 1; tick();
    chk("R8 ls set wins", 32'(pending[0]), 1);
    lsr_rd = 1; tick();
    chk("R4 cleared again", 32'(pending[0]), 0);
  endtask

  task automatic t_txrdy();
    tx_ready_evt = 1; tick();
    chk("R5 set", 32'(pending[3]), 1);
    msr_rd = 1; lsr_rd = 1; tick();
    chk("R5 other reads ignored", 32'(pending[3]), 1);
    isr_rd = 1; tick();
    chk("R5 isr read clears", 32'(pending[3]), 0);
    tx_ready_evt = 1; isr_rd = 1; tick();
    chk("R8 tx set wins", 32'(pending[3]), 1);
    isr_rd = 1; tick();
  endtask

  task automatic t_modem();
    modem_evt = 1; tick();
    chk("R6 modem delta", 32'(pending[4]), 1);
    isr_rd = 1; lsr_rd = 1; tick();
    chk("R6 other reads ignored", 32'(pending[4]), 1);
    msr_rd = 1; tick();
    chk("R6 msr clears", 32'(pending[4]), 0);
    rtscts_evt = 1; tick();
    chk("R6 rts/cts delta", 32'(pending[4]), 1);
    msr_rd = 1; tick();
    dtrdsr_evt = 1; tick();
    chk("R6 dtr/dsr delta", 32'(pending[4]), 1);
    msr_rd = 1; tick();
    chk("R6 cleared", 32'(pending[4]), 0);
  endtask

  task automatic t_flow();
    xonxoff_evt = 1; tick();
    chk("R7 xon/xoff", 32'(pending[5]), 1);
    msr_rd = 1; lsr_rd = 1; tick();
    chk("R7 other reads ignored", 32'(pending[5]), 1);
    isr_rd = 1; tick();
    chk("R7 isr clears", 32'(pending[5]), 0);
    spchar_evt = 1; tick();
    chk("R7 special char", 32'(pending[5]), 1);
    isr_rd = 1; tick();
    chk("R7 cleared", 32'(pending[5]), 0);
  endtask

  task automatic t_prio();
    src_enable = 6'h3f;
    rx_fifo_empty = 0; rx_fifo_count = 2;
    ls_evt = 1; rx_timeout_evt = 1; tx_ready_evt = 1; modem_evt = 1; xonxoff_evt = 1;
    tick();
    chk("R10 all pending", 32'(pending), 32'h3b);
    chk("R10 line status first", 32'(irq_code), 1);
    chk("R9 irq up", 32'(irq), 1);
    lsr_rd = 1; rx_fifo_count = 4; tick();
    chk("R10 time-out next", 32'(irq_code), 2);
    src_enable = 6'h3d; #1;
    chk("R9 disabled rxto kept pending", 32'(pending[1]), 1);
    chk("R10 masked rxto skipped", 32'(irq_code), 3);
    @(negedge clk);
    isr_rd = 1; rx_fifo_count = 0; rx_fifo_empty = 1; tick();
    chk("R10 modem remains", 32'(irq_code), 5);
    chk("R10 pending modem only", 32'(pending), 32'h10);
    msr_rd = 1; tick();
    chk("R9 irq drops", 32'(irq), 0);
    chk("R10 code none", 32'(irq_code), 0);
    tx_ready_evt = 1; tick();
    src_enable = 6'h37; #1;
    chk("R9 disabled tx no irq", 32'(irq), 0);
    chk("R9 disabled tx no code", 32'(irq_code), 0);
    chk("R9 disabled tx pending", 32'(pending[3]), 1);
    src_enable = 6'h3f; #1;
    chk("R9 enable restores irq", 32'(irq), 1);
    @(negedge clk);
    isr_rd = 1; tick();
  endtask

  initial begin
    t_reset();
    t_rxrdy();
    t_rxto();
    t_lstat();
    t_txrdy();
    t_modem();
    t_flow();
    t_prio();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule